// File: doc/BRIEF.md
# Packet-Number Service Queue Port

This block keeps two short first-in first-out queues of buffer packet numbers. One queue lists received frames that still wait for software, and the other lists transmitted frames whose completion software has not yet acknowledged. The receive engine and the transmit engine each push a packet number with a one-cycle strobe. Both queue heads are visible at the same time through one 16-bit read-only status word.

The upper byte of the status word describes the receive queue and the lower byte describes the transmit-completion queue. Each byte holds an empty flag and the head packet number. Reading the word never changes either queue. The receive head leaves its queue only on a remove-frame command strobe, and the transmit-completion head leaves only on a transmit-interrupt acknowledge strobe. Each queue also drives an interrupt status line that software can poll. The packet number is passed through unmasked, so the value read can be written straight back as a packet selector.

Top module: `pktnum_queue_port`

## Requirements
- R1: After reset the status word reads 16'h8080, and both interrupt lines and both overflow flags are low.
- R2: Status bit 15 is set exactly when the receive queue is empty. Bits 13:8 carry the receive head packet number, all six bits unmasked (63 reads back as 63). Bit 14 reads zero.
- R3: Status bit 7 is set exactly when the transmit-completion queue is empty. Bits 5:0 carry its head packet number unmasked. Bit 6 reads zero.
- R4: Each queue delivers its packet numbers in push order. While a queue is empty, its packet-number field reads zero.
- R5: The receive queue is popped only by `rx_remove`, and the transmit-completion queue only by `tx_ack`. A strobe for one queue leaves the other queue unchanged.
- R6: `rx_int` equals the inverse of status bit 15 and `tx_int` equals the inverse of status bit 7 in every cycle.
- R7: Each queue holds 16 entries. A push into a full queue with no pop in the same cycle is dropped and sets that queue's overflow flag. The flag stays set until reset.
- R8: A push and a pop in the same cycle leave the occupancy unchanged, and this holds when the queue is full. The popped head is replaced by the next entry in order.
- R9: A pop strobe on an empty queue has no effect.
- R10: The status word and the interrupt lines are registered. A push or pop sampled at clock edge k is visible after edge k+1 and not after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Receive engine enqueues `rx_push_pn` |
| rx_push_pn | input | 6 | Packet number to enqueue on the receive queue |
| rx_remove | input | 1 | Remove-frame command, pops the receive head |
| tx_push | input | 1 | Transmit engine enqueues `tx_push_pn` |
| tx_push_pn | input | 6 | Packet number to enqueue on the completion queue |
| tx_ack | input | 1 | Transmit-interrupt acknowledge, pops the completion head |
| fifo_port | output | 16 | Status word: receive byte high, completion byte low |
| rx_int | output | 1 | Receive queue non-empty |
| tx_int | output | 1 | Completion queue non-empty |
| rx_ovf | output | 1 | Sticky: a receive push was dropped |
| tx_ovf | output | 1 | Sticky: a completion push was dropped |

## Verification
The bench fills the receive queue to all 16 entries while the completion queue receives different values, then pushes into the full queue. A design that wraps its pointers early or late, or that loses the overflow flag, shows a wrong head value or a clear flag here. It checks a push and a pop in the same cycle, both on a full queue and on a partly filled one. A design that refuses the push when the queue is full, or that miscounts the occupancy, then shows the wrong order during the drain or becomes empty too early. The bench strobes pops on empty queues and strobes each queue's pop while the other queue holds entries. A design with crossed pop wiring, or with an occupancy count that can go below zero, shows a wrong byte. It also samples the status word one cycle after a push, where a design with an unregistered output would already show the new value.

// File: rtl/pnq_pkg.sv
package pnq_pkg;
  localparam int PN_W     = 6;
  localparam int BYTE_W   = 8;
  localparam int FLAG_BIT = 7;
  localparam int NQ       = 2;
  localparam int Q_RX     = 1;
  localparam int Q_TX     = 0;

  // One status byte: empty flag on top, spare bit zero, head number below.
  function automatic logic [BYTE_W-1:0] pack_status(input logic empty,
                                                    input logic [PN_W-1:0] pn);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[FLAG_BIT] = empty;
    b[PN_W-1:0] = empty ? '0 : pn;
    return b;
  endfunction
endpackage

// File: rtl/pn_fifo.sv
module pn_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_pn,
  input  logic         pop,
  output logic [W-1:0] head_q,
  output logic         empty_q,
  output logic         busy_q,
  output logic         ovf_q
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_pop, do_push;

  assign do_pop  = pop && (count != '0);
  assign do_push = push && ((count != (AW+1)'(DEPTH)) || do_pop);

  // Storage kept free of reset so a block RAM can hold it.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_pn;
  end

  // Registered read of the head.
  always_ff @(posedge clk) begin
    head_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      ovf_q   <= 1'b0;
      empty_q <= 1'b1;
      busy_q  <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && !do_push) ovf_q <= 1'b1;
      empty_q <= (count == '0);
      busy_q  <= (count != '0);
    end
  end
endmodule

// File: rtl/pktnum_queue_port.sv
module pktnum_queue_port #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_push,
  input  logic [5:0]  rx_push_pn,
  input  logic        rx_remove,
  input  logic        tx_push,
  input  logic [5:0]  tx_push_pn,
  input  logic        tx_ack,
  output logic [15:0] fifo_port,
  output logic        rx_int,
  output logic        tx_int,
  output logic        rx_ovf,
  output logic        tx_ovf
);
  import pnq_pkg::*;

  logic [NQ-1:0]           q_push, q_pop, q_empty, q_busy, q_ovf;
  logic [PN_W-1:0]         q_pn   [NQ];
  logic [PN_W-1:0]         q_head [NQ];
  logic [NQ*BYTE_W-1:0]    word;

  assign q_push[Q_RX] = rx_push;
  assign q_pn[Q_RX]   = rx_push_pn;
  assign q_pop[Q_RX]  = rx_remove;
  assign q_push[Q_TX] = tx_push;
  assign q_pn[Q_TX]   = tx_push_pn;
  assign q_pop[Q_TX]  = tx_ack;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    pn_fifo #(.DEPTH(DEPTH), .W(PN_W)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .push    (q_push[g]),
      .push_pn (q_pn[g]),
      .pop     (q_pop[g]),
      .head_q  (q_head[g]),
      .empty_q (q_empty[g]),
      .busy_q  (q_busy[g]),
      .ovf_q   (q_ovf[g])
    );
    assign word[g*BYTE_W +: BYTE_W] = pack_status(q_empty[g], q_head[g]);
  end

  assign fifo_port = word;
  assign rx_int    = q_busy[Q_RX];
  assign tx_int    = q_busy[Q_TX];
  assign rx_ovf    = q_ovf[Q_RX];
  assign tx_ovf    = q_ovf[Q_TX];
endmodule

// File: rtl/pnq_checker.sv
module pnq_checker (
  input logic        clk,
  input logic        rst,
  input logic        rx_push,
  input logic        rx_remove,
  input logic        tx_push,
  input logic        tx_ack,
  input logic [15:0] fifo_port,
  input logic        rx_int,
  input logic        tx_int,
  input logic        rx_ovf,
  input logic        tx_ovf
);
  AST_RX_INT_FLAG: assert property (@(posedge clk) disable iff (rst) rx_int == !fifo_port[15]); // R6
  AST_TX_INT_FLAG: assert property (@(posedge clk) disable iff (rst) tx_int == !fifo_port[7]); // R6
  AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst) fifo_port[15] |-> fifo_port[13:8] == 6'd0); // R4
  AST_TX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst) fifo_port[7] |-> fifo_port[5:0] == 6'd0); // R4
  AST_RX_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) rx_ovf |=> rx_ovf); // R7
  AST_TX_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) tx_ovf |=> tx_ovf); // R7
  AST_RX_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst) (!rx_push && !rx_remove) |=> ##1 $stable(fifo_port[15:8])); // R5
  AST_TX_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst) (!tx_push && !tx_ack) |=> ##1 $stable(fifo_port[7:0])); // R5
endmodule

bind pktnum_queue_port pnq_checker u_pnq_checker (
  .clk       (clk),
  .rst       (rst),
  .rx_push   (rx_push),
  .rx_remove (rx_remove),
  .tx_push   (tx_push),
  .tx_ack    (tx_ack),
  .fifo_port (fifo_port),
  .rx_int    (rx_int),
  .tx_int    (tx_int),
  .rx_ovf    (rx_ovf),
  .tx_ovf    (tx_ovf)
);

// File: tb/pktnum_queue_port_bench.sv
module pktnum_queue_port_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_push = 1'b0, rx_remove = 1'b0, tx_push = 1'b0, tx_ack = 1'b0;
  logic [5:0] rx_push_pn = '0, tx_push_pn = '0;
  logic [15:0] fifo_port;
  logic rx_int, tx_int, rx_ovf, tx_ovf;

  int checks = 0, fails = 0;
  logic [5:0] mrx[$];
  logic [5:0] mtx[$];
  logic erx_ovf = 1'b0, etx_ovf = 1'b0;

  always #10 clk = ~clk;

  pktnum_queue_port u_pktnum_queue_port (
    .clk(clk), .rst(rst),
    .rx_push(rx_push), .rx_push_pn(rx_push_pn), .rx_remove(rx_remove),
    .tx_push(tx_push), .tx_push_pn(tx_push_pn), .tx_ack(tx_ack),
    .fifo_port(fifo_port), .rx_int(rx_int), .tx_int(tx_int),
    .rx_ovf(rx_ovf), .tx_ovf(tx_ovf)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word();
    logic [15:0] w;
    w = 16'h8080;
    if (mrx.size() != 0) w[15:8] = {2'b00, mrx[0]};
    if (mtx.size() != 0) w[7:0]  = {2'b00, mtx[0]};
    return w;
  endfunction

  task automatic check_all(input string tag);
    chk(tag, fifo_port, exp_word());
    chk("R6 rx_int", {15'd0, rx_int}, {15'd0, mrx.size() != 0});
    chk("R6 tx_int", {15'd0, tx_int}, {15'd0, mtx.size() != 0});
    chk("R7 rx_ovf", {15'd0, rx_ovf}, {15'd0, erx_ovf});
    chk("R7 tx_ovf", {15'd0, tx_ovf}, {15'd0, etx_ovf});
  endtask

  // Model update for one queue; returns via refs.
  task automatic model(ref logic [5:0] q[$], ref logic ovf,
                       input logic p, input logic [5:0] pn, input logic pp);
    logic popped, pushed;
    popped = pp && (q.size() != 0);
    pushed = p && ((q.size() < 16) || popped);
    if (popped) void'(q.pop_front());
    if (pushed) q.push_back(pn);
    if (p && !pushed) ovf = 1'b1;
  endtask

  task automatic op(input string tag,
                    input logic rp, input logic [5:0] rpn, input logic rr,
                    input logic tp, input logic [5:0] tpn, input logic ta);
    @(negedge clk);
    rx_push = rp; rx_push_pn = rpn; rx_remove = rr;
    tx_push = tp; tx_push_pn = tpn; tx_ack = ta;
    @(negedge clk);
    rx_push = 0; rx_remove = 0; tx_push = 0; tx_ack = 0;
    model(mrx, erx_ovf, rp, rpn, rr);
    model(mtx, etx_ovf, tp, tpn, ta);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 reset");

    // R10: one edge after the push the word is still old.
    @(negedge clk);
    rx_push = 1; rx_push_pn = 6'h2A;
    @(negedge clk);
    rx_push = 0;
    chk("R10 not yet visible", fifo_port, 16'h8080);
    chk("R10 int not yet", {15'd0, rx_int}, 16'd0);
    mrx.push_back(6'h2A);
    @(negedge clk);
    check_all("R10 visible");

    // Fill rx to full, tx in parallel with different values (R2, R3, R4).
    for (int i = 1; i < 16; i++)
      op("R2 R3 R4 fill", 1, 6'((i * 7 + 3) & 63), 0, (i < 10), 6'((i * 5 + 1) & 63), 0);
    // Push into full rx: dropped, flag set (R7).
    op("R7 full drop", 1, 6'h3F, 0, 0, 6'h00, 0);
    // Push and pop together while full (R8).
    op("R8 full push+pop", 1, 6'h3F, 1, 0, 6'h00, 0);
    // Remove frames from rx only; tx must stay (R5).
    for (int i = 0; i < 8; i++)
      op("R5 rx remove", 0, 6'h00, 1, 0, 6'h00, 0);
    // tx ack only; rx must stay (R5).
    for (int i = 0; i < 3; i++)
      op("R5 tx ack", 0, 6'h00, 0, 0, 6'h00, 1);
    // Push and pop together on a partly filled tx queue (R8).
    for (int i = 0; i < 4; i++)
      op("R8 tx push+pop", 0, 6'h00, 0, 1, 6'(60 + i), 1);
    // Drain both, past empty (R9, R4).
    for (int i = 0; i < 12; i++)
      op("R9 R4 drain", 0, 6'h00, 1, 0, 6'h00, 1);
    op("R9 pop empty", 0, 6'h00, 1, 0, 6'h00, 1);
    // Unmasked all-ones value in both bytes (R2, R3).
    op("R2 R3 all ones", 1, 6'h3F, 0, 1, 6'h3F, 0);
    // Fill tx to overflow (R7).
    for (int i = 0; i < 17; i++)
      op("R7 tx fill", 0, 6'h00, 0, 1, 6'(i), 0);
    op("R7 sticky", 0, 6'h00, 1, 0, 6'h00, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule